// File: doc/BRIEF.md
# Single-Cycle Integer Unit with Carry Flag

This block is the integer execution unit of a 32-bit RISC pipeline. In one cycle it forms an add, a reverse subtract (operand B minus operand A), a signed or unsigned compare, one of four bitwise operations, a one-bit right shift, or a byte or halfword sign extension. Operand B is whatever the issue stage selected, register or immediate; the unit does not care which.

The unit owns the carry bit of the machine status word. Adds and reverse subtracts may fold the current carry into the sum and may be told to leave the carry alone; right shifts always load the bit that falls off operand A. The carry register changes only when a valid, unstalled operation asks for it. Opcodes the unit does not implement, including the floating-point group, raise an illegal flag, return zero and leave the carry untouched.

The result is combinational from the operands, the opcode and the current carry; the carry update takes effect at the next rising clock edge.

Top module: `ialu_top`

## Requirements
- R1: While `rstN` is low the carry flag is cleared, and it reads 0 at the first cycle after reset.
- R2: Opcode 0 (add) returns A + B + (useCarryIn ? carry : 0) modulo 2^32, and the carry flag takes the carry out of bit 31.
- R3: Opcode 1 (reverse subtract) returns B + ~A + (useCarryIn ? carry : 1) modulo 2^32, and the carry flag takes the carry out of bit 31.
- R4: For opcodes 0 and 1 with keepCarry high, the result is formed as usual but the carry flag keeps its value.
- R5: Opcodes 2 (signed) and 3 (unsigned) compare: bits 30..0 of the result equal those of B - A, bit 31 is 1 exactly when A is greater than B under that signedness, and the carry flag is not changed.
- R6: Opcodes 4, 5, 6, 7 return A|B, A&B, A^B and A&~B respectively, carry unchanged.
- R7: Opcodes 8, 9, 10 shift A right by one; bit 31 of the result is A[31] for opcode 8, the old carry flag for opcode 9 and 0 for opcode 10; the carry flag takes A[0] regardless of keepCarry.
- R8: Opcode 11 copies A[7] into bits 31..8 above A[7:0]; opcode 12 copies A[15] into bits 31..16 above A[15:0]; carry unchanged.
- R9: Opcodes 13, 14 and 15 (13 being the floating-point group) drive `illegal` high and the result to 0, and never change the carry flag; for all other opcodes `illegal` is low.
- R10: When `opValid` is low or `stall` is high, the carry flag does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| opValid | input | 1 | An operation is present this cycle |
| stall | input | 1 | Pipeline hold; blocks the carry update |
| opCode | input | 4 | Operation select (see requirements) |
| useCarryIn | input | 1 | Fold the carry flag into add / reverse subtract |
| keepCarry | input | 1 | Do not update carry on add / reverse subtract |
| opA | input | 32 | Operand A |
| opB | input | 32 | Operand B (register or immediate) |
| result | output | 32 | Operation result |
| carryFlag | output | 1 | Current machine-status carry bit |
| illegal | output | 1 | Unimplemented opcode indication |

## Verification
On every cycle the assertions check that the carry holds across stalls and invalid cycles, that keepCarry freezes it for add and reverse subtract, that a shift loads it from the old A[0], that an illegal opcode yields zero, and that reset clears it. The arithmetic values themselves (carry-in folding, the reverse-subtract increment, the compare MSB under both signednesses, the shift MSB flavours and the sign-extension widths) are shown only by the bench's directed scenarios, which compare against independently computed values including overflow and sign-boundary operands.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

  localparam logic [3:0] OP_ADD    = 4'd0;
  localparam logic [3:0] OP_RSUB   = 4'd1;
  localparam logic [3:0] OP_CMP    = 4'd2;
  localparam logic [3:0] OP_CMPU   = 4'd3;
  localparam logic [3:0] OP_OR     = 4'd4;
  localparam logic [3:0] OP_AND    = 4'd5;
  localparam logic [3:0] OP_XOR    = 4'd6;
  localparam logic [3:0] OP_ANDN   = 4'd7;
  localparam logic [3:0] OP_SRA    = 4'd8;
  localparam logic [3:0] OP_SRC    = 4'd9;
  localparam logic [3:0] OP_SRL    = 4'd10;
  localparam logic [3:0] OP_SEXT8  = 4'd11;
  localparam logic [3:0] OP_SEXT16 = 4'd12;

  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cinSel_e;
  typedef enum logic [2:0] {RES_SUM, RES_CMP, RES_LOGIC, RES_SHIFT, RES_SEXT, RES_ZERO} resSel_e;
  typedef enum logic [1:0] {MSB_ZERO, MSB_SIGN, MSB_CARRY} shMsb_e;
  typedef enum logic [1:0] {LG_OR, LG_AND, LG_XOR, LG_ANDN} logicOp_e;

  typedef struct packed {
    resSel_e  resSel;
    cinSel_e  cinSel;
    logic     invA;
    logicOp_e logicOp;
    shMsb_e   shMsb;
    logic     sextHalf;
    logic     cmpSigned;
    logic     carryFromShift;
    logic     carryWe;
  } aluStrobe_t;

endpackage

// File: rtl/ialu_ctrl.sv
module ialu_ctrl
  import ialu_pkg::*;
(
  input  logic       opValid,
  input  logic       stall,
  input  logic [3:0] opCode,
  input  logic       useCarryIn,
  input  logic       keepCarry,
  output aluStrobe_t strb,
  output logic       illegal
);

  logic sumUpdates;
  logic shiftUpdates;

  always_comb begin
    strb = '{resSel: RES_ZERO, cinSel: CIN_ZERO, invA: 1'b0, logicOp: LG_OR,
             shMsb: MSB_ZERO, sextHalf: 1'b0, cmpSigned: 1'b0,
             carryFromShift: 1'b0, carryWe: 1'b0};
    illegal      = 1'b0;
    sumUpdates   = 1'b0;
    shiftUpdates = 1'b0;
    case (opCode)
      OP_ADD: begin
        strb.resSel = RES_SUM;
        strb.cinSel = useCarryIn ? CIN_FLAG : CIN_ZERO;
        sumUpdates  = 1'b1;
      end
      OP_RSUB: begin
        strb.resSel = RES_SUM;
        strb.invA   = 1'b1;
        strb.cinSel = useCarryIn ? CIN_FLAG : CIN_ONE;
        sumUpdates  = 1'b1;
      end
      OP_CMP, OP_CMPU: begin
        strb.resSel    = RES_CMP;
        strb.invA      = 1'b1;
        strb.cinSel    = CIN_ONE;
        strb.cmpSigned = (opCode == OP_CMP);
      end
      OP_OR:   begin strb.resSel = RES_LOGIC; strb.logicOp = LG_OR;   end
      OP_AND:  begin strb.resSel = RES_LOGIC; strb.logicOp = LG_AND;  end
      OP_XOR:  begin strb.resSel = RES_LOGIC; strb.logicOp = LG_XOR;  end
      OP_ANDN: begin strb.resSel = RES_LOGIC; strb.logicOp = LG_ANDN; end
      OP_SRA, OP_SRC, OP_SRL: begin
        strb.resSel         = RES_SHIFT;
        strb.carryFromShift = 1'b1;
        shiftUpdates        = 1'b1;
        strb.shMsb = (opCode == OP_SRA) ? MSB_SIGN :
                     (opCode == OP_SRC) ? MSB_CARRY : MSB_ZERO;
      end
      OP_SEXT8:  begin strb.resSel = RES_SEXT; strb.sextHalf = 1'b0; end
      OP_SEXT16: begin strb.resSel = RES_SEXT; strb.sextHalf = 1'b1; end
      default: begin
        strb.resSel = RES_ZERO;
        illegal     = 1'b1;
      end
    endcase
    strb.carryWe = opValid && !stall && ((sumUpdates && !keepCarry) || shiftUpdates);
  end

  // R9: an unimplemented opcode never requests a carry write
  always_comb begin
    if (illegal) a_illegal_nowrite_r9: assert (!strb.carryWe);
  end

endmodule

// File: rtl/ialu_dpath.sv
module ialu_dpath
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              carryFlag
);

  localparam int SUM_W  = DATA_W + 1;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  logic [DATA_W-1:0] aOperand;
  logic              cinBit;
  logic [SUM_W-1:0]  sumFull;
  logic              aGreater;
  logic [DATA_W-1:0] cmpRes;
  logic [DATA_W-1:0] logicRes;
  logic              shiftTop;
  logic [DATA_W-1:0] shiftRes;
  logic [DATA_W-1:0] sextRes;
  logic              carryNext;

  always_comb begin
    aOperand = strb.invA ? ~opA : opA;
    case (strb.cinSel)
      CIN_ONE:  cinBit = 1'b1;
      CIN_FLAG: cinBit = carryFlag;
      default:  cinBit = 1'b0;
    endcase
    sumFull = {1'b0, opB} + {1'b0, aOperand} + {{DATA_W{1'b0}}, cinBit};
  end

  always_comb begin
    aGreater = strb.cmpSigned ? ($signed(opA) > $signed(opB)) : (opA > opB);
    cmpRes   = {aGreater, sumFull[DATA_W-2:0]};
  end

  always_comb begin
    case (strb.logicOp)
      LG_OR:   logicRes = opA | opB;
      LG_AND:  logicRes = opA & opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = opA & ~opB;
    endcase
  end

  always_comb begin
    case (strb.shMsb)
      MSB_SIGN:  shiftTop = opA[DATA_W-1];
      MSB_CARRY: shiftTop = carryFlag;
      default:   shiftTop = 1'b0;
    endcase
    shiftRes = {shiftTop, opA[DATA_W-1:1]};
  end

  always_comb begin
    if (strb.sextHalf)
      sextRes = {{(DATA_W-HALF_W){opA[HALF_W-1]}}, opA[HALF_W-1:0]};
    else
      sextRes = {{(DATA_W-BYTE_W){opA[BYTE_W-1]}}, opA[BYTE_W-1:0]};
  end

  always_comb begin
    case (strb.resSel)
      RES_SUM:   result = sumFull[DATA_W-1:0];
      RES_CMP:   result = cmpRes;
      RES_LOGIC: result = logicRes;
      RES_SHIFT: result = shiftRes;
      RES_SEXT:  result = sextRes;
      default:   result = '0;
    endcase
  end

  assign carryNext = strb.carryFromShift ? opA[0] : sumFull[DATA_W];

  always_ff @(posedge clk) begin
    if (!rstN)             carryFlag <= 1'b0;
    else if (strb.carryWe) carryFlag <= carryNext;
  end

  // R1: reset clears the carry
  p_reset_clear_r1: assert property (@(posedge clk) !rstN |=> !carryFlag);

  // R10: no write strobe, no carry change
  p_hold_nowe_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.carryWe |=> $stable(carryFlag));

endmodule

// File: rtl/ialu_top.sv
module ialu_top
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              stall,
  input  logic [3:0]        opCode,
  input  logic              useCarryIn,
  input  logic              keepCarry,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              carryFlag,
  output logic              illegal
);

  aluStrobe_t strb;

  ialu_ctrl u_ctrl (
    .opValid    (opValid),
    .stall      (stall),
    .opCode     (opCode),
    .useCarryIn (useCarryIn),
    .keepCarry  (keepCarry),
    .strb       (strb),
    .illegal    (illegal)
  );

  ialu_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opA       (opA),
    .opB       (opB),
    .result    (result),
    .carryFlag (carryFlag)
  );

  // R10: stalled or empty cycles leave the carry alone
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stall || !opValid) |=> $stable(carryFlag));

  // R4: keep bit freezes carry on add / reverse subtract
  p_keep_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !stall && keepCarry && (opCode == OP_ADD || opCode == OP_RSUB))
      |=> $stable(carryFlag));

  // R7: shift loads the bit leaving A
  p_shift_carry_r7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !stall && (opCode == OP_SRA || opCode == OP_SRC || opCode == OP_SRL))
      |=> (carryFlag == $past(opA[0])));

  // R9: illegal opcodes give zero and keep carry
  p_illegal_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (result == '0));
  p_illegal_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    illegal |=> $stable(carryFlag));

endmodule

// File: tb/tb_ialu_top.sv
module tb_ialu_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic        stall = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic        useCarryIn = 1'b0;
  logic        keepCarry = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] result;
  logic        carryFlag;
  logic        illegal;

  int total = 0;
  int bad = 0;
  logic expC = 1'b0;

  always #5 clk = ~clk;

  ialu_top dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .stall(stall), .opCode(opCode),
    .useCarryIn(useCarryIn), .keepCarry(keepCarry), .opA(opA), .opB(opB),
    .result(result), .carryFlag(carryFlag), .illegal(illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one op, check result/illegal combinationally, then carry after the edge
  task automatic runOp(input string req, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic uc, input logic kc,
                       input logic v, input logic st,
                       input logic [31:0] expRes, input logic expIll, input logic newC);
    @(negedge clk);
    opCode = op; opA = a; opB = b; useCarryIn = uc; keepCarry = kc;
    opValid = v; stall = st;
    #1;
    chk({req, " result"}, result, expRes);
    chk({req, " illegal"}, {31'd0, illegal}, {31'd0, expIll});
    @(negedge clk);
    opValid = 1'b0; stall = 1'b0;
    expC = newC;
    chk({req, " carry"}, {31'd0, carryFlag}, {31'd0, expC});
  endtask

  task automatic setCarry(input logic c);
    runOp("R7 setup", 4'd10, {31'd0, c}, 32'd0, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0, 1'b0, c);
  endtask

  task automatic tReset;
    chk("R1 reset carry", {31'd0, carryFlag}, 32'd0);
  endtask

  task automatic tAdd;
    logic [32:0] s;
    s = {1'b0, 32'hFFFF_FFFF} + 33'd1;
    runOp("R2 add overflow", 4'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, 1, 0, s[31:0], 0, s[32]);
    // carry now 1, fold it in
    s = {1'b0, 32'h1234_0000} + {1'b0, 32'h0000_5678} + 33'd1;
    runOp("R2 add carry-in", 4'd0, 32'h1234_0000, 32'h0000_5678, 1, 0, 1, 0, s[31:0], 0, s[32]);
  endtask

  task automatic tRsub;
    logic [32:0] s;
    s = {1'b0, 32'd100} + {1'b0, ~32'd30} + 33'd1;
    runOp("R3 rsub", 4'd1, 32'd30, 32'd100, 0, 0, 1, 0, 32'd70, 0, s[32]);
    setCarry(1'b0);
    s = {1'b0, 32'd5} + {1'b0, ~32'd9} + 33'd0;
    runOp("R3 rsub carry-in", 4'd1, 32'd9, 32'd5, 1, 0, 1, 0, s[31:0], 0, s[32]);
  endtask

  task automatic tKeep;
    setCarry(1'b0);
    runOp("R4 keep add", 4'd0, 32'hFFFF_FFFF, 32'd2, 0, 1, 1, 0, 32'd1, 0, 1'b0);
    setCarry(1'b1);
    runOp("R4 keep rsub", 4'd1, 32'd1, 32'd0, 0, 1, 1, 0, 32'hFFFF_FFFF, 0, 1'b1);
  endtask

  task automatic tCmp;
    logic [31:0] d;
    d = 32'h0000_0005 - 32'hFFFF_FFFF;
    // signed: -1 > 5 false
    runOp("R5 cmp signed", 4'd2, 32'hFFFF_FFFF, 32'd5, 0, 0, 1, 0, {1'b0, d[30:0]}, 0, expC);
    // unsigned: FFFFFFFF > 5 true
    runOp("R5 cmp unsigned", 4'd3, 32'hFFFF_FFFF, 32'd5, 0, 0, 1, 0, {1'b1, d[30:0]}, 0, expC);
    d = 32'h8000_0000 - 32'd7;
    runOp("R5 cmp signed gt", 4'd2, 32'd7, 32'h8000_0000, 0, 0, 1, 0, {1'b1, d[30:0]}, 0, expC);
  endtask

  task automatic tLogic;
    logic [31:0] a, b;
    a = 32'hF0F0_1234; b = 32'h0FF0_FF00;
    runOp("R6 or",   4'd4, a, b, 0, 0, 1, 0, a | b,  0, expC);
    runOp("R6 and",  4'd5, a, b, 0, 0, 1, 0, a & b,  0, expC);
    runOp("R6 xor",  4'd6, a, b, 0, 0, 1, 0, a ^ b,  0, expC);
    runOp("R6 andn", 4'd7, a, b, 0, 0, 1, 0, a & ~b, 0, expC);
  endtask

  task automatic tShift;
    setCarry(1'b1);
    runOp("R7 sra", 4'd8, 32'h8000_0002, 0, 0, 1, 1, 0, 32'hC000_0001, 0, 1'b0);
    runOp("R7 src carry0", 4'd9, 32'h0000_0003, 0, 0, 0, 1, 0, 32'h0000_0001, 0, 1'b1);
    runOp("R7 src carry1", 4'd9, 32'h0000_0004, 0, 0, 0, 1, 0, 32'h8000_0002, 0, 1'b0);
    runOp("R7 srl", 4'd10, 32'hFFFF_FFFF, 0, 0, 0, 1, 0, 32'h7FFF_FFFF, 0, 1'b1);
  endtask

  task automatic tSext;
    runOp("R8 sext8 neg",  4'd11, 32'h1234_5680, 0, 0, 0, 1, 0, 32'hFFFF_FF80, 0, expC);
    runOp("R8 sext8 pos",  4'd11, 32'hFFFF_FF7F, 0, 0, 0, 1, 0, 32'h0000_007F, 0, expC);
    runOp("R8 sext16 neg", 4'd12, 32'h0000_8001, 0, 0, 0, 1, 0, 32'hFFFF_8001, 0, expC);
  endtask

  task automatic tIllegal;
    setCarry(1'b1);
    for (int k = 13; k < 16; k++)
      runOp("R9 illegal", 4'(k), 32'hFFFF_FFFF, 32'd1, 0, 0, 1, 0, 32'd0, 1, 1'b1);
  endtask

  task automatic tStall;
    setCarry(1'b0);
    runOp("R10 stalled add", 4'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, 1, 1, 32'd0, 0, 1'b0);
    runOp("R10 invalid shift", 4'd10, 32'd1, 0, 0, 0, 0, 0, 32'd0, 0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    tReset();
    tAdd();
    tRsub();
    tKeep();
    tCmp();
    tLogic();
    tShift();
    tSext();
    tIllegal();
    tStall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule